// File: doc/BRIEF.md
# Partitioned X Operand Shift Register

This block holds the X operand of a bit-serial modular multiplier and hands it out one bit per multiplier step. The operand is captured in parallel as an N-bit word. Each advance request shifts the stored word right by one place and fills the top with a zero. The serial output bit then moves on to the next operand bit.

The multiplier array behind this block can run as its lower part, its upper part, or its full range. The part is chosen by a 2-bit select. When only the upper part is active, the serial bit comes from a fixed offset inside the register. That offset equals the bit count of the lower part, `(N/T)*TL`. In every other case the serial bit is the register LSB. A synchronous clear empties the register.

Control is a small decoder. Each clock it picks one of four named operations: OP_CLEAR, OP_LOAD, OP_SHIFT and OP_HOLD. The choice is by fixed priority: clear first, then load, then shift, and hold when no request is present. The storage register is the block's only state, and the chosen operation is the transition applied to it. The part select is decoded into PART_LOW, PART_HIGH and PART_FULL. The code 2'b00 decodes to PART_FULL.

Top module: `xop_shift_feed`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register is cleared to all zeros, so `bit_out` reads 0 for every `part_sel` code. `rst` has priority over `ld` and `adv` in the same cycle.
- R2: With `rst` low and `ld` high at a rising edge, the whole `x_in` word is captured. Afterwards, with `part_sel`=2'b11, `bit_out` equals `x_in[0]`.
- R3: With `rst` and `ld` low and `adv` high at a rising edge, the stored word shifts right by one. After k such shifts following a load of X, with `part_sel`=2'b11, `bit_out` equals X[k].
- R4: `part_sel`=2'b01 (lower part) takes `bit_out` from the register LSB.
- R5: `part_sel`=2'b10 (upper part) takes `bit_out` from register bit LOW_BITS = (N/T)*TL, which is 16 with the defaults. After k shifts this is X[16+k].
- R6: `part_sel`=2'b11 (full range) and `part_sel`=2'b00 both take `bit_out` from the register LSB.
- R7: When `ld` and `adv` are both high with `rst` low, the load wins. Afterwards the register holds `x_in` unshifted.
- R8: Every shift brings a zero into the MSB. After N shifts, `bit_out` is 0 in every part. In the upper part it is 0 after N-LOW_BITS shifts.
- R9: With `rst`, `ld` and `adv` all low, the register keeps its value, so `bit_out` is unchanged for each `part_sel` code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous clear, active high |
| x_in | input | N | Parallel operand word |
| ld | input | 1 | Capture `x_in` this cycle |
| adv | input | 1 | Shift to the next operand bit |
| part_sel | input | 2 | Array part: 01 lower, 10 upper, 11 or 00 full |
| bit_out | output | 1 | Serial operand bit |

## Verification
The assertions place no conditions on the inputs. `ld`, `adv` and `rst` may arrive in any combination and on any cycle, and `part_sel` may change at any time because the output tap is purely combinational. The stimulus mixes random combinations of all three controls with random `part_sel` codes, including 2'b00. It adds directed sequences: load and advance together, clear together with load, and runs of N shifts that drain the register. The parameters must keep N a multiple of T and TL below T. Elaboration rejects any other setting, so the stimulus never needs to cover it.

// File: rtl/xop_shift_pkg.sv
package xop_shift_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } xop_op_e;

    typedef enum logic [1:0] {
        PART_FULL = 2'd0,
        PART_LOW  = 2'd1,
        PART_HIGH = 2'd2
    } xop_part_e;

    function automatic xop_part_e decode_part(input logic [1:0] code);
        xop_part_e p;
        unique case (code)
            2'b01:   p = PART_LOW;
            2'b10:   p = PART_HIGH;
            default: p = PART_FULL;   // 2'b11 and 2'b00
        endcase
        return p;
    endfunction

endpackage

// File: rtl/xop_ctrl.sv
module xop_ctrl
    import xop_shift_pkg::*;
(
    input  logic    rst,
    input  logic    ld,
    input  logic    adv,
    output xop_op_e op
);

    always_comb begin
        unique casez ({rst, ld, adv})
            3'b1??:  op = OP_CLEAR;
            3'b01?:  op = OP_LOAD;
            3'b001:  op = OP_SHIFT;
            default: op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/xop_store.sv
module xop_store
    import xop_shift_pkg::*;
#(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  xop_op_e      op,
    input  logic [N-1:0] din,
    output logic [N-1:0] q
);

    logic [N-1:0] q_next;

    always_comb begin
        unique case (op)
            OP_CLEAR: q_next = '0;
            OP_LOAD:  q_next = din;
            OP_SHIFT: q_next = {1'b0, q[N-1:1]};
            default:  q_next = q;
        endcase
    end

    always_ff @(posedge clk) begin
        q <= q_next;
    end

    assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (q == '0));

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (ld_seen(op)) |=> (q == $past(din)));

    assert_shift_R3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT) |=> (q == ($past(q) >> 1)));

    assert_zero_fill_R8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT) |=> (q[N-1] == 1'b0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |=> $stable(q));

    function automatic logic ld_seen(input xop_op_e o);
        return o == OP_LOAD;
    endfunction

endmodule

// File: rtl/xop_tap.sv
module xop_tap
    import xop_shift_pkg::*;
#(
    parameter int N        = 64,
    parameter int LOW_BITS = 16
) (
    input  logic [N-1:0] q,
    input  xop_part_e    part,
    output logic         bit_out
);

    logic hi_bit;

    generate
        if (LOW_BITS == 0) begin : g_no_offset
            assign hi_bit = q[0];
        end else begin : g_offset
            assign hi_bit = q[LOW_BITS];
        end
    endgenerate

    always_comb begin
        unique case (part)
            PART_HIGH: bit_out = hi_bit;
            PART_LOW:  bit_out = q[0];
            default:   bit_out = q[0];
        endcase
    end

endmodule

// File: rtl/xop_shift_feed.sv
module xop_shift_feed
    import xop_shift_pkg::*;
#(
    parameter int N  = 64,
    parameter int T  = 8,
    parameter int TL = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] x_in,
    input  logic         ld,
    input  logic         adv,
    input  logic [1:0]   part_sel,
    output logic         bit_out
);

    localparam int BITS_PER_STAGE = N / T;
    localparam int LOW_BITS       = BITS_PER_STAGE * TL;

    generate
        if ((N % T) != 0 || TL >= T || TL < 0) begin : g_bad_params
            $error("xop_shift_feed: N must be a multiple of T and TL below T");
        end
    endgenerate

    xop_op_e   op;
    xop_part_e part;
    logic [N-1:0] q;

    assign part = decode_part(part_sel);

    xop_ctrl u_ctrl (
        .rst (rst),
        .ld  (ld),
        .adv (adv),
        .op  (op)
    );

    xop_store #(.N(N)) u_store (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .din (x_in),
        .q   (q)
    );

    xop_tap #(.N(N), .LOW_BITS(LOW_BITS)) u_tap (
        .q       (q),
        .part    (part),
        .bit_out (bit_out)
    );

    assert_load_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (ld && adv) |=> (q == $past(x_in)));

    assert_lower_lsb_R4: assert property (@(posedge clk) disable iff (rst)
        (part_sel == 2'b01) |-> (bit_out == q[0]));

    assert_upper_offset_R5: assert property (@(posedge clk) disable iff (rst)
        (part_sel == 2'b10) |-> (bit_out == q[LOW_BITS]));

    assert_full_lsb_R6: assert property (@(posedge clk) disable iff (rst)
        (part_sel == 2'b11 || part_sel == 2'b00) |-> (bit_out == q[0]));

endmodule

// File: tb/xop_shift_feed_tb_top.sv
module xop_shift_feed_tb_top;

    localparam int N   = 64;
    localparam int LOW = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] x_in = '0;
    logic         ld = 1'b0;
    logic         adv = 1'b0;
    logic [1:0]   part_sel = 2'b11;
    logic         bit_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [N-1:0] model = '0;

    always #5 clk = ~clk;

    xop_shift_feed dut_i (
        .clk(clk), .rst(rst), .x_in(x_in), .ld(ld), .adv(adv),
        .part_sel(part_sel), .bit_out(bit_out)
    );

    function automatic logic exp_bit(input logic [N-1:0] m, input logic [1:0] p);
        return (p == 2'b10) ? m[LOW] : m[0];
    endfunction

    function automatic logic [N-1:0] next_model(input logic [N-1:0] m, input logic r,
                                               input logic l, input logic a,
                                               input logic [N-1:0] x);
        if (r) return '0;
        if (l) return x;
        if (a) return m >> 1;
        return m;
    endfunction

    task automatic chk(input logic got, input logic expv, input string req);
        checks++;
        if (got !== expv) begin
            fails++;
            $display("FAIL %s part_sel=%b got=%b exp=%b t=%0t", req, part_sel, got, expv, $time);
        end
    endtask

    // apply one clock with given controls; inputs change on the falling edge
    task automatic step(input logic r, input logic l, input logic a, input logic [N-1:0] x);
        rst = r; ld = l; adv = a; x_in = x;
        @(posedge clk);
        model = next_model(model, r, l, a, x);
        @(negedge clk);
        rst = 1'b0; ld = 1'b0; adv = 1'b0;
    endtask

    task automatic check_all(input string req);
        for (int p = 0; p < 4; p++) begin
            part_sel = p[1:0];
            #1;
            chk(bit_out, exp_bit(model, part_sel), req);
        end
    endtask

    initial begin
        logic [N-1:0] x;
        logic prev;
        @(negedge clk);
        step(1'b1, 1'b0, 1'b0, '0);
        check_all("R1");

        // load and read both taps
        x = 64'hA5C3_0F1E_7788_1235;
        step(1'b0, 1'b1, 1'b0, x);
        part_sel = 2'b11; #1; chk(bit_out, x[0], "R2");
        part_sel = 2'b01; #1; chk(bit_out, x[0], "R4");
        part_sel = 2'b10; #1; chk(bit_out, x[LOW], "R5");
        part_sel = 2'b00; #1; chk(bit_out, x[0], "R6");

        for (int k = 1; k <= 5; k++) begin
            step(1'b0, 1'b0, 1'b1, '0);
            part_sel = 2'b11; #1; chk(bit_out, x[k], "R3");
            part_sel = 2'b10; #1; chk(bit_out, x[LOW+k], "R5");
        end

        // hold
        step(1'b0, 1'b0, 1'b0, '1);
        check_all("R9");

        // load wins over advance
        x = 64'h8000_0000_0001_0002;
        step(1'b0, 1'b1, 1'b1, x);
        part_sel = 2'b11; #1; chk(bit_out, x[0], "R7");
        part_sel = 2'b10; #1; chk(bit_out, x[LOW], "R7");

        // clear beats load
        step(1'b1, 1'b1, 1'b0, '1);
        check_all("R1");

        // drain all ones
        step(1'b0, 1'b1, 1'b0, '1);
        for (int k = 1; k <= N; k++) begin
            step(1'b0, 1'b0, 1'b1, '0);
            part_sel = 2'b10; #1;
            prev = (k >= N - LOW) ? 1'b0 : 1'b1;
            chk(bit_out, prev, "R8");
        end
        check_all("R8");

        // constrained random
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom();
            step(r[7:0] == 8'd0, r[10:8] == 3'd0, r[12], {$urandom(), $urandom()});
            part_sel = r[21:20]; #1;
            chk(bit_out, exp_bit(model, part_sel), "R3");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule